// File: doc/BRIEF.md
# Cycle-Stealing Data Channel Controller

This controller lets peripheral devices reach a word-addressed memory without any program step. Each device code owns one line of a request vector. When the controller is idle it grants the lowest eligible code, shows that code to the devices on a select output, and raises a hold output that keeps the processor off the memory until the transfer is over. The granted device then drives two words on the inbound bus on two successive clocks: first the memory address, together with a 2-bit operation code, and then a data word.

Four operations exist. A device can write its word into memory, or read a memory word back. It can also increment a memory word in place, or add its own word to a memory word in place. The last two are read-modify-write cycles, which serve signal averaging and pulse-height histogramming. The controller produces all of the transfer timing, so devices need no timing logic of their own. A one-clock acknowledge closes each transfer. In that acknowledge clock the controller also presents the read data and the carry-out of an increment or add.

Top module: `dchan_ctrl`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, hold, ack, ovf, sel_valid and mem_en are all 0.
- R2: The controller grants the lowest requesting device code in the range 1 to 62. Codes 0 and 63 are reserved and never granted. A request on those codes alone leaves the controller idle with hold low.
- R3: Operation code 2 (increment) writes (M+1) mod 2^16 back to the same address. ovf is 1 in the ack clock exactly when M was 0xFFFF. ovf is never high outside an ack clock.
- R4: Operation code 3 (add) writes (M+D) mod 2^16 back, where D is the device's data word. ovf is 1 in the ack clock exactly when M+D exceeds 0xFFFF.
- R5: Operation code 0 (write) stores the device's data word at the address and reports ovf 0.
- R6: Operation code 1 (read) leaves memory unchanged. bus_out carries the memory word in the ack clock. bus_out is 0 in the ack clock of every other operation.
- R7: ack is high for exactly one clock per transfer, at its end.
- R8: hold is high from the grant clock through the ack clock and low in the clock after. Requests raised during a transfer are granted only after it ends. mem_en is active only while hold is high.
- R9: In the clock where sel_valid is high (the address phase, the first clock of hold), bus_in carries the 16-bit address and op_in the operation. In the next clock, bus_in carries the device data word.
- R10: Counting the address-phase clock as 0, ack is high in clock 3 for a write, clock 4 for a read and clock 5 for an increment or add.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_req | input | 64 | One request line per device code |
| op_in | input | 2 | Operation code, sampled in the address phase |
| bus_in | input | 16 | Device-to-controller bus: address, then data |
| bus_out | output | 16 | Read data toward the device, valid in the ack clock |
| sel_valid | output | 1 | Address phase active for the code on sel_code |
| sel_code | output | 6 | Granted device code |
| ack | output | 1 | One-clock end-of-transfer strobe |
| ovf | output | 1 | Carry-out of an increment or add, in the ack clock |
| hold | output | 1 | Processor kept off memory |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write when high, read when low |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, one clock after a read |

## Verification
The bench drives increments of 0x00FF and 0xFFFF and adds that carry, do not carry, and wrap to exactly zero. A design that kept the carry, dropped it, or wrote the old word back would show a wrong memory word or a wrong ovf. Mixed request vectors containing both reserved codes check grant order. A highest-code-first arbiter, or one that served code 0 or 63, would present the wrong sel_code or leave hold high when only reserved codes ask. A request raised in the middle of a transfer has to wait its turn, and each operation's ack has to land on its exact clock. A read that still wrote, or an ack held for two clocks, shows up as changed memory, wrong latency or a late low on ack.

// File: rtl/dchan_pkg.sv
package dchan_pkg;

    // Operation encoding shared by the sequencer and the arithmetic unit
    typedef enum logic [1:0] {
        OP_WR  = 2'd0,   // device word into memory
        OP_RD  = 2'd1,   // memory word out to device
        OP_INC = 2'd2,   // memory word plus one, in place
        OP_ADD = 2'd3    // memory word plus device word, in place
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_ADDR  = 3'd1,
        S_DATA  = 3'd2,
        S_MRD   = 3'd3,
        S_MWAIT = 3'd4,
        S_MWR   = 3'd5,
        S_ACK   = 3'd6
    } st_e;

endpackage

// File: rtl/dchan_arbiter.sv
module dchan_arbiter #(
    parameter int NCODES = 64,
    localparam int CW = $clog2(NCODES)
) (
    input  logic [NCODES-1:0] req,
    output logic              gnt_valid,
    output logic [CW-1:0]     gnt_code
);

    logic [NCODES-1:0] eligible;

    // The lowest and the all-ones code are masked off permanently
    for (genvar g = 0; g < NCODES; g++) begin : g_mask
        if (g == 0 || g == NCODES - 1) begin : g_rsv
            assign eligible[g] = 1'b0;
        end else begin : g_use
            assign eligible[g] = req[g];
        end
    end

    // Scan from the top so the last hit, the lowest code, wins
    always_comb begin
        gnt_code  = '0;
        gnt_valid = 1'b0;
        for (int i = NCODES - 1; i >= 0; i--) begin
            if (eligible[i]) begin
                gnt_code  = CW'(i);
                gnt_valid = 1'b1;
            end
        end
    end

endmodule

// File: rtl/dchan_alu.sv
module dchan_alu
    import dchan_pkg::*;
#(
    parameter int DW = 16
) (
    input  op_e           op,
    input  logic [DW-1:0] mem_word,
    input  logic [DW-1:0] dev_word,
    output logic [DW-1:0] result,
    output logic          carry
);

    logic [DW-1:0] addend;
    logic [DW:0]   sum;

    always_comb begin
        addend = (op == OP_INC) ? DW'(1) : dev_word;
        sum    = {1'b0, mem_word} + {1'b0, addend};
        result = sum[DW-1:0];
        carry  = sum[DW];
    end

endmodule

// File: rtl/dchan_seq.sv
module dchan_seq
    import dchan_pkg::*;
#(
    parameter int DW = 16,
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          gnt_valid,
    input  logic [CW-1:0] gnt_code,
    input  logic [1:0]    op_in,
    input  logic [DW-1:0] bus_in,
    input  logic [DW-1:0] mem_rdata,
    input  logic [DW-1:0] alu_result,
    input  logic          alu_carry,
    output op_e           alu_op,
    output logic [DW-1:0] alu_dev,
    output logic [DW-1:0] bus_out,
    output logic          sel_valid,
    output logic [CW-1:0] sel_code,
    output logic          ack,
    output logic          ovf,
    output logic          hold,
    output logic          mem_en,
    output logic          mem_we,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata
);

    typedef struct packed {
        st_e           st;
        logic [CW-1:0] code;
        op_e           op;
        logic [DW-1:0] addr;
        logic [DW-1:0] dev;
        logic [DW-1:0] mdata;
        logic          ovf;
    } ctx_t;

    ctx_t ctx_q, ctx_d;

    always_comb begin
        ctx_d = ctx_q;
        unique case (ctx_q.st)
            S_IDLE: begin
                if (gnt_valid) begin
                    ctx_d.st   = S_ADDR;
                    ctx_d.code = gnt_code;
                    ctx_d.ovf  = 1'b0;
                end
            end
            S_ADDR: begin
                ctx_d.addr = bus_in;
                ctx_d.op   = op_e'(op_in);
                ctx_d.st   = S_DATA;
            end
            S_DATA: begin
                ctx_d.dev = bus_in;
                ctx_d.st  = (ctx_q.op == OP_WR) ? S_MWR : S_MRD;
            end
            S_MRD: begin
                ctx_d.st = S_MWAIT;
            end
            S_MWAIT: begin
                if (ctx_q.op == OP_RD) begin
                    ctx_d.mdata = mem_rdata;
                    ctx_d.st    = S_ACK;
                end else begin
                    ctx_d.mdata = alu_result;
                    ctx_d.ovf   = alu_carry;
                    ctx_d.st    = S_MWR;
                end
            end
            S_MWR: begin
                ctx_d.st = S_ACK;
            end
            S_ACK: begin
                ctx_d.st = S_IDLE;
            end
            default: begin
                ctx_d.st = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= '{st: S_IDLE, code: '0, op: OP_WR, addr: '0,
                       dev: '0, mdata: '0, ovf: 1'b0};
        end else begin
            ctx_q <= ctx_d;
        end
    end

    // Outputs decoded from registered state only
    always_comb begin
        alu_op    = ctx_q.op;
        alu_dev   = ctx_q.dev;
        hold      = (ctx_q.st != S_IDLE);
        sel_valid = (ctx_q.st == S_ADDR);
        sel_code  = sel_valid ? ctx_q.code : '0;
        ack       = (ctx_q.st == S_ACK);
        ovf       = ack && ctx_q.ovf;
        bus_out   = (ack && ctx_q.op == OP_RD) ? ctx_q.mdata : '0;
        mem_en    = (ctx_q.st == S_MRD) || (ctx_q.st == S_MWR);
        mem_we    = (ctx_q.st == S_MWR);
        mem_addr  = mem_en ? ctx_q.addr : '0;
        mem_wdata = mem_we ? ((ctx_q.op == OP_WR) ? ctx_q.dev : ctx_q.mdata) : '0;
    end

endmodule

// File: rtl/dchan_ctrl.sv
module dchan_ctrl
    import dchan_pkg::*;
#(
    parameter int DW     = 16,
    parameter int NCODES = 64,
    localparam int CW    = $clog2(NCODES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCODES-1:0] dev_req,
    input  logic [1:0]        op_in,
    input  logic [DW-1:0]     bus_in,
    output logic [DW-1:0]     bus_out,
    output logic              sel_valid,
    output logic [CW-1:0]     sel_code,
    output logic              ack,
    output logic              ovf,
    output logic              hold,
    output logic              mem_en,
    output logic              mem_we,
    output logic [DW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic [DW-1:0]     mem_rdata
);

    logic          gnt_valid;
    logic [CW-1:0] gnt_code;
    op_e           alu_op;
    logic [DW-1:0] alu_dev;
    logic [DW-1:0] alu_result;
    logic          alu_carry;

    dchan_arbiter #(.NCODES(NCODES)) u_arb (
        .req       (dev_req),
        .gnt_valid (gnt_valid),
        .gnt_code  (gnt_code)
    );

    dchan_alu #(.DW(DW)) u_alu (
        .op       (alu_op),
        .mem_word (mem_rdata),
        .dev_word (alu_dev),
        .result   (alu_result),
        .carry    (alu_carry)
    );

    dchan_seq #(.DW(DW), .CW(CW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .gnt_valid  (gnt_valid),
        .gnt_code   (gnt_code),
        .op_in      (op_in),
        .bus_in     (bus_in),
        .mem_rdata  (mem_rdata),
        .alu_result (alu_result),
        .alu_carry  (alu_carry),
        .alu_op     (alu_op),
        .alu_dev    (alu_dev),
        .bus_out    (bus_out),
        .sel_valid  (sel_valid),
        .sel_code   (sel_code),
        .ack        (ack),
        .ovf        (ovf),
        .hold       (hold),
        .mem_en     (mem_en),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata)
    );

endmodule

// File: rtl/dchan_ctrl_chk.sv
module dchan_ctrl_chk #(
    parameter int CW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          hold,
    input logic          ack,
    input logic          ovf,
    input logic          sel_valid,
    input logic [CW-1:0] sel_code,
    input logic          mem_en
);

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!hold && !ack && !mem_en && !sel_valid))
        else $error("reset state violated");

    p_no_reserved_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> (sel_code != '0 && sel_code != '1))
        else $error("reserved code granted");

    p_ovf_in_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> ack)
        else $error("ovf outside ack");

    p_ack_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack)
        else $error("ack longer than one clock");

    p_ack_under_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> hold)
        else $error("ack without hold");

    p_hold_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !hold)
        else $error("hold not released after ack");

    p_mem_under_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> hold)
        else $error("memory access without hold");

    p_hold_starts_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold) |-> sel_valid)
        else $error("hold rose outside address phase");

endmodule

bind dchan_ctrl dchan_ctrl_chk #(.CW(CW)) u_chk (.*);

// File: tb/dchan_ctrl_test.sv
module dchan_ctrl_test;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] dev_req = '0;
    logic [1:0]  op_in = '0;
    logic [15:0] bus_in = '0;
    logic [15:0] bus_out;
    logic        sel_valid;
    logic [5:0]  sel_code;
    logic        ack, ovf, hold;
    logic        mem_en, mem_we;
    logic [15:0] mem_addr, mem_wdata;
    logic [15:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    dchan_ctrl uut (
        .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .op_in(op_in),
        .bus_in(bus_in), .bus_out(bus_out), .sel_valid(sel_valid),
        .sel_code(sel_code), .ack(ack), .ovf(ovf), .hold(hold),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Bench memory: 256 words indexed by the low address byte
    logic [15:0] mem [256];
    logic        pre_en = 1'b0;
    logic [7:0]  pre_addr = '0;
    logic [15:0] pre_data = '0;

    always @(posedge clk) begin
        if (pre_en) mem[pre_addr] <= pre_data;
        else if (mem_en && mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        if (mem_en && !mem_we) mem_rdata <= mem[mem_addr[7:0]];
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic preload(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        pre_en = 1'b1; pre_addr = a; pre_data = d;
        @(negedge clk);
        pre_en = 1'b0;
    endtask

    // One transfer: adds reqs to the request vector, serves the grant,
    // raises late_req during the data phase, returns observations
    task automatic xfer(input logic [63:0] reqs, input logic [1:0] op,
                        input logic [15:0] addr, input logic [15:0] data,
                        input logic [63:0] late_req,
                        output logic [5:0] got_code, output int lat,
                        output logic [15:0] got_out, output logic got_ovf,
                        output logic ack_after, output logic hold_after,
                        output logic hold_seen);
        dev_req = dev_req | reqs;
        hold_seen = 1'b1;
        for (int w = 0; w < 20; w++) begin
            @(negedge clk);
            if (sel_valid) break;
        end
        got_code = sel_code;
        bus_in = addr; op_in = op;
        @(negedge clk);
        bus_in = data;
        dev_req = dev_req | late_req;
        lat = 1;
        for (int w = 0; w < 20; w++) begin
            @(negedge clk);
            lat = lat + 1;
            if (!hold) hold_seen = 1'b0;
            if (ack) break;
        end
        got_out = bus_out;
        got_ovf = ovf;
        dev_req[got_code] = 1'b0;
        bus_in = '0; op_in = '0;
        @(negedge clk);
        ack_after = ack;
        hold_after = hold;
    endtask

    typedef struct packed {
        logic [1:0]  op;
        logic [5:0]  code;
        logic [15:0] addr;
        logic [15:0] pre;
        logic [15:0] data;
        logic [15:0] exp_mem;
        logic [15:0] exp_out;
        logic        exp_ovf;
    } vec_t;

    // op: 0 write, 1 read, 2 increment, 3 add
    localparam vec_t VECS [8] = '{
        '{2'd0, 6'd5,  16'h0010, 16'h1111, 16'hABCD, 16'hABCD, 16'h0000, 1'b0},
        '{2'd1, 6'd62, 16'h0020, 16'h1234, 16'h5555, 16'h1234, 16'h1234, 1'b0},
        '{2'd2, 6'd1,  16'h0030, 16'h00FF, 16'h7777, 16'h0100, 16'h0000, 1'b0},
        '{2'd2, 6'd9,  16'h0031, 16'hFFFF, 16'h0000, 16'h0000, 16'h0000, 1'b1},
        '{2'd3, 6'd17, 16'h0040, 16'h1000, 16'h0234, 16'h1234, 16'h0000, 1'b0},
        '{2'd3, 6'd33, 16'h0041, 16'hF000, 16'h2001, 16'h1001, 16'h0000, 1'b1},
        '{2'd3, 6'd44, 16'h0042, 16'h8000, 16'h8000, 16'h0000, 16'h0000, 1'b1},
        '{2'd1, 6'd2,  16'h00FF, 16'hBEEF, 16'h0000, 16'hBEEF, 16'hBEEF, 1'b0}
    };

    initial begin
        logic [5:0]  gc;
        int          lat;
        logic [15:0] gout;
        logic        gov, aa, ha, hs;
        int          exp_lat;

        // R1: reset state
        repeat (3) @(negedge clk);
        check(!hold && !ack && !ovf && !sel_valid && !mem_en, "R1 during reset",
              {hold, ack, ovf, sel_valid, mem_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!hold && !ack && !ovf && !sel_valid && !mem_en, "R1 after release",
              {hold, ack, ovf, sel_valid, mem_en}, 0);

        // Vector table: R3 R4 R5 R6 R7 R9 R10
        foreach (VECS[i]) begin
            preload(VECS[i].addr[7:0], VECS[i].pre);
            xfer(64'd1 << VECS[i].code, VECS[i].op, VECS[i].addr, VECS[i].data,
                 '0, gc, lat, gout, gov, aa, ha, hs);
            exp_lat = (VECS[i].op == 2'd0) ? 3 : (VECS[i].op == 2'd1) ? 4 : 5;
            check(gc == VECS[i].code, "R2 granted code", gc, VECS[i].code);
            check(lat == exp_lat, "R10 ack latency", lat, exp_lat);
            check(mem[VECS[i].addr[7:0]] == VECS[i].exp_mem, "R3/R4/R5/R6 memory word R9",
                  mem[VECS[i].addr[7:0]], VECS[i].exp_mem);
            check(gout == VECS[i].exp_out, "R6 bus_out in ack", gout, VECS[i].exp_out);
            check(gov == VECS[i].exp_ovf, "R3 R4 ovf in ack", gov, VECS[i].exp_ovf);
            check(!aa, "R7 ack single clock", aa, 0);
            check(hs && !ha, "R8 hold window", {hs, ha}, 2'b10);
        end

        // R2: reserved codes alone are never granted
        dev_req = 64'h8000_0000_0000_0001;
        repeat (10) begin
            @(negedge clk);
            if (hold || sel_valid) break;
        end
        check(!hold && !sel_valid, "R2 reserved codes ignored", {hold, sel_valid}, 0);

        // R2: lowest eligible wins with reserved codes also asking;
        // R8: a late request waits for the running transfer
        preload(8'h50, 16'h0001);
        xfer((64'd1 << 40) | (64'd1 << 7), 2'd2, 16'h0050, 16'h0000, '0,
             gc, lat, gout, gov, aa, ha, hs);
        check(gc == 6'd7, "R2 lowest code first", gc, 7);
        xfer('0, 2'd2, 16'h0050, 16'h0000, 64'd1 << 3,
             gc, lat, gout, gov, aa, ha, hs);
        check(gc == 6'd40, "R2 second grant", gc, 40);
        check(mem[8'h50] == 16'h0003, "R3 two increments", mem[8'h50], 16'h0003);
        xfer('0, 2'd1, 16'h0050, 16'h0000, '0, gc, lat, gout, gov, aa, ha, hs);
        check(gc == 6'd3, "R8 late request served after", gc, 3);
        check(gout == 16'h0003, "R6 read after increments", gout, 16'h0003);
        dev_req = '0;

        // R5: write does not report overflow even with all-ones data
        preload(8'h60, 16'hFFFF);
        xfer(64'd1 << 12, 2'd0, 16'h0060, 16'hFFFF, '0, gc, lat, gout, gov, aa, ha, hs);
        check(!gov && mem[8'h60] == 16'hFFFF, "R5 write no ovf", {gov, mem[8'h60]}, 17'h0FFFF);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule